// File: doc/BRIEF.md
# Phase-Shift PWM Generator

This block drives a motor's high-side switch with a pulse-width modulated signal. The signal is built from two free-running counters that share one period length. Each counter emits a one-cycle wrap pulse once per period. The pulse from the leading counter sets an SR latch, and the pulse from the trailing counter clears it. The duty cycle is therefore the phase offset between the two counters, counted in clock cycles.

A speed controller adjusts the duty by choosing which counter slips. Once per update interval, which lasts a parameterised number of PWM periods, the selected counter advances by two counts instead of one. This moves its pulse one cycle earlier. Force inputs override the latch, so the state machine can hold the output fully on or fully off.

When the set and reset pulses coincide, the duty has reached one of its ends. The block reports the rising edge of that coincidence as a one-cycle saturation pulse, tagged as full or zero from the slip direction in force at the time. After reset the counters are in phase, so overlap pulses appear from the very first period.

Top module: `pwm_phase_gen`

## Requirements
- R1: While reset is held, and after it is released, `pwm_gate_n_o` is 1 (switch off) and both saturation outputs are 0, until a slip or a force changes this. The two counters start in phase.
- R2: If `shift_set_i` and `shift_clr_i` are both 0 or both 1, neither counter slips. The phase offset and the duty do not change across update intervals.
- R3: With `shift_set_i`=1 and `shift_clr_i`=0, each update interval of PERIOD*UPDATE_PERIODS cycles adds one cycle of on-time (`pwm_gate_n_o`=0) per PERIOD-cycle window.
- R4: With `shift_set_i`=0 and `shift_clr_i`=1, each update interval removes one cycle of on-time per PERIOD-cycle window.
- R5: A set-counter wrap pulse alone turns the output on (`pwm_gate_n_o` goes to 0). A reset-counter wrap pulse alone turns it off (`pwm_gate_n_o` goes to 1). The driven level is the inverse of the latch.
- R6: When the two wrap pulses coincide, the latch keeps its state. A zero offset reached by clearing slips gives 0% on-time, and one reached by setting slips gives 100% on-time.
- R7: `force_full_i`=1 drives `pwm_gate_n_o` to 0 and `force_off_i`=1 drives it to 1. `force_off_i` wins when both are set. Neither force changes the latch, so the previous duty returns when the forces are released.
- R8: At the first cycle of each set/reset pulse coincidence, `sat_full_o` pulses for one cycle if the set counter is selected, and `sat_zero_o` pulses if the reset counter is selected. With no selection, neither pulses, and the two are never high together.
- R9: Exactly one slip occurs per update interval. Slipping past 100% wraps the offset modulo PERIOD, so one more set slip after full on-time gives one cycle of on-time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_set_i | input | 1 | Selects the set counter for slipping (raises duty) |
| shift_clr_i | input | 1 | Selects the reset counter for slipping (lowers duty) |
| force_off_i | input | 1 | Pins the switch off |
| force_full_i | input | 1 | Pins the switch fully on |
| pwm_gate_n_o | output | 1 | Active-low switch gate drive |
| sat_full_o | output | 1 | One-cycle pulse: overlap reached while raising duty |
| sat_zero_o | output | 1 | One-cycle pulse: overlap reached while lowering duty |

## Verification
The hardest state to reach is a zero phase offset arrived at from the high side. The latch must then hold full on-time and report a full saturation pulse, and one more slip must wrap the duty back to a single cycle. Getting there needs a full period's worth of set slips, one per update interval. The bench therefore runs with a short period and a short update interval, keeps its own cycle count that is aligned to the update strobe, and changes direction and force inputs only in the quiet half of each interval. Each PERIOD-cycle measurement window then sees one settled offset, and its on-time and saturation-pulse counts can be compared with a running offset model.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    // Which counter receives the extra count at an update strobe
    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_SET  = 2'd1,
        SLIP_CLR  = 2'd2
    } slip_sel_e;

    // Wrap pulses of the two phase counters
    typedef struct packed {
        logic set_p;
        logic clr_p;
    } edge_pair_t;

    // Saturation events sent to the speed state machine
    typedef struct packed {
        logic full;
        logic zero;
    } sat_evt_t;

    // Exactly one select line picks a counter; none or both pick nothing
    function automatic slip_sel_e decode_slip(input logic sel_set, input logic sel_clr);
        if (sel_set && !sel_clr) return SLIP_SET;
        if (sel_clr && !sel_set) return SLIP_CLR;
        return SLIP_NONE;
    endfunction

endpackage

// File: rtl/pwm_update_timer.sv
module pwm_update_timer #(
    parameter int PERIOD         = 256,
    parameter int UPDATE_PERIODS = 50
) (
    input  logic clk,
    input  logic rst,
    output logic upd_o
);
    localparam int LIMIT = PERIOD * UPDATE_PERIODS;
    localparam int TW    = $clog2(LIMIT);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] tick_cnt;

    assign upd_o = (tick_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)        tick_cnt <= '0;
        else if (upd_o) tick_cnt <= '0;
        else            tick_cnt <= tick_cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
    parameter int PERIOD = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic slip_i,
    output logic wrap_o
);
    localparam int W = $clog2(PERIOD);
    localparam logic [W:0] PER_V = (W+1)'(PERIOD);

    logic [W-1:0] phase_q;
    logic [W:0]   phase_sum;
    logic         crosses;

    // A slip advances two counts; a wrap is flagged whenever the sum crosses the period
    assign phase_sum = {1'b0, phase_q} + (W+1)'(slip_i ? 2 : 1);
    assign crosses   = (phase_sum >= PER_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            wrap_o  <= 1'b0;
        end else begin
            wrap_o  <= crosses;
            phase_q <= crosses ? W'(phase_sum - PER_V) : W'(phase_sum);
        end
    end
endmodule

// File: rtl/pwm_latch_drive.sv
module pwm_latch_drive
    import pwm_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t pulses_i,
    input  logic       force_off_i,
    input  logic       force_full_i,
    output logic       gate_n_o
);
    logic on_q;

    // Set alone turns on, clear alone turns off, coincidence holds
    always_ff @(posedge clk) begin
        if (rst)                                    on_q <= 1'b0;
        else if (pulses_i.set_p && !pulses_i.clr_p) on_q <= 1'b1;
        else if (pulses_i.clr_p && !pulses_i.set_p) on_q <= 1'b0;
    end

    // Active-low gate; off-force dominates
    always_comb begin
        if (force_off_i)       gate_n_o = 1'b1;
        else if (force_full_i) gate_n_o = 1'b0;
        else                   gate_n_o = ~on_q;
    end
endmodule

// File: rtl/pwm_overlap_detect.sv
module pwm_overlap_detect
    import pwm_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t pulses_i,
    input  slip_sel_e  sel_i,
    output sat_evt_t   sat_o
);
    logic overlap;
    logic overlap_q;
    logic overlap_rise;

    assign overlap      = pulses_i.set_p & pulses_i.clr_p;
    assign overlap_rise = overlap & ~overlap_q;

    always_ff @(posedge clk) begin
        if (rst) overlap_q <= 1'b0;
        else     overlap_q <= overlap;
    end

    always_comb begin
        sat_o.full = overlap_rise && (sel_i == SLIP_SET);
        sat_o.zero = overlap_rise && (sel_i == SLIP_CLR);
    end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
    import pwm_phase_pkg::*;
#(
    parameter int PERIOD         = 256,
    parameter int UPDATE_PERIODS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_set_i,
    input  logic shift_clr_i,
    input  logic force_off_i,
    input  logic force_full_i,
    output logic pwm_gate_n_o,
    output logic sat_full_o,
    output logic sat_zero_o
);
    slip_sel_e  slip_sel;
    logic       upd_tick;
    logic [1:0] wrap_v;
    edge_pair_t pulses;
    sat_evt_t   sat_evt;

    assign slip_sel = decode_slip(shift_set_i, shift_clr_i);

    pwm_update_timer #(
        .PERIOD         (PERIOD),
        .UPDATE_PERIODS (UPDATE_PERIODS)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .upd_o (upd_tick)
    );

    // Index 0 is the set counter, index 1 the reset counter
    for (genvar gi = 0; gi < 2; gi++) begin : g_ctr
        localparam slip_sel_e OWN_SEL = (gi == 0) ? SLIP_SET : SLIP_CLR;
        logic slip_here;
        assign slip_here = upd_tick && (slip_sel == OWN_SEL);
        pwm_phase_counter #(.PERIOD(PERIOD)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .slip_i (slip_here),
            .wrap_o (wrap_v[gi])
        );
    end

    assign pulses.set_p = wrap_v[0];
    assign pulses.clr_p = wrap_v[1];

    pwm_latch_drive u_drive (
        .clk          (clk),
        .rst          (rst),
        .pulses_i     (pulses),
        .force_off_i  (force_off_i),
        .force_full_i (force_full_i),
        .gate_n_o     (pwm_gate_n_o)
    );

    pwm_overlap_detect u_overlap (
        .clk      (clk),
        .rst      (rst),
        .pulses_i (pulses),
        .sel_i    (slip_sel),
        .sat_o    (sat_evt)
    );

    assign sat_full_o = sat_evt.full;
    assign sat_zero_o = sat_evt.zero;
endmodule

// File: rtl/pwm_phase_gen_checker.sv
module pwm_phase_gen_checker #(
    parameter int PERIOD         = 256,
    parameter int UPDATE_PERIODS = 50
) (
    input logic clk,
    input logic rst,
    input logic force_off_i,
    input logic force_full_i,
    input logic pwm_gate_n_o,
    input logic sat_full_o,
    input logic sat_zero_o,
    input logic set_p,
    input logic clr_p,
    input logic upd
);
    localparam int LIMIT = PERIOD * UPDATE_PERIODS;
    localparam int GW    = $clog2(LIMIT) + 1;

    logic [GW-1:0] gap;
    logic          unforced;

    assign unforced = !force_off_i && !force_full_i;

    always_ff @(posedge clk) begin
        if (rst)      gap <= '0;
        else if (upd) gap <= '0;
        else          gap <= gap + 1'b1;
    end

    // R9: update strobes are spaced exactly one interval apart
    assert_upd_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        upd |-> (gap == GW'(LIMIT - 1)));

    // R8: the saturation tags are exclusive and last one cycle
    assert_sat_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sat_full_o, sat_zero_o}));
    assert_sat_single_R8: assert property (@(posedge clk) disable iff (rst)
        (sat_full_o || sat_zero_o) |=> !(sat_full_o || sat_zero_o));

    // R5: an unforced turn-on follows a lone set pulse, a turn-off a lone clear pulse
    assert_on_after_set_R5: assert property (@(posedge clk) disable iff (rst)
        (unforced && $past(unforced) && $fell(pwm_gate_n_o)) |-> $past(set_p && !clr_p));
    assert_off_after_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (unforced && $past(unforced) && $rose(pwm_gate_n_o)) |-> $past(clr_p && !set_p));

    // R6: coincident pulses leave the output unchanged
    assert_overlap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (set_p && clr_p && unforced) |=> (force_off_i || force_full_i || $stable(pwm_gate_n_o)));

    // R7: off-force always wins
    assert_force_off_R7: assert property (@(posedge clk) disable iff (rst)
        force_off_i |-> pwm_gate_n_o);
endmodule

bind pwm_phase_gen pwm_phase_gen_checker #(
    .PERIOD         (PERIOD),
    .UPDATE_PERIODS (UPDATE_PERIODS)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .force_off_i  (force_off_i),
    .force_full_i (force_full_i),
    .pwm_gate_n_o (pwm_gate_n_o),
    .sat_full_o   (sat_full_o),
    .sat_zero_o   (sat_zero_o),
    .set_p        (pulses.set_p),
    .clr_p        (pulses.clr_p),
    .upd          (upd_tick)
);

// File: tb/pwm_phase_gen_bench.sv
`timescale 1ns/1ps
module pwm_phase_gen_bench;
    localparam int P  = 16;
    localparam int U  = 4;
    localparam int IV = P * U;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_set_i = 1'b0;
    logic shift_clr_i = 1'b0;
    logic force_off_i = 1'b0;
    logic force_full_i = 1'b0;
    logic pwm_gate_n_o, sat_full_o, sat_zero_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    pwm_phase_gen #(.PERIOD(P), .UPDATE_PERIODS(U)) u_pwm_phase_gen (
        .clk          (clk),
        .rst          (rst),
        .shift_set_i  (shift_set_i),
        .shift_clr_i  (shift_clr_i),
        .force_off_i  (force_off_i),
        .force_full_i (force_full_i),
        .pwm_gate_n_o (pwm_gate_n_o),
        .sat_full_o   (sat_full_o),
        .sat_zero_o   (sat_zero_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_phase(input int m);
        do @(negedge clk); while ((cyc % IV) != m);
    endtask

    // Measure one PERIOD-long window in the settled part of an interval
    task automatic window_check(input int exp_on, input int exp_full, input int exp_zero,
                                input string tag);
        int on_cnt = 0;
        int full_cnt = 0;
        int zero_cnt = 0;
        wait_phase(20);
        for (int i = 0; i < P; i++) begin
            if (!pwm_gate_n_o) on_cnt++;
            if (sat_full_o)    full_cnt++;
            if (sat_zero_o)    zero_cnt++;
            @(negedge clk);
        end
        check(on_cnt == exp_on, {tag, " on-time"}, on_cnt, exp_on);
        check(full_cnt == exp_full, {tag, " sat_full count"}, full_cnt, exp_full);
        check(zero_cnt == exp_zero, {tag, " sat_zero count"}, zero_cnt, exp_zero);
    endtask

    task automatic set_inputs(input int phase, input logic s, input logic c,
                              input logic fo, input logic ff);
        wait_phase(phase);
        shift_set_i  = s;
        shift_clr_i  = c;
        force_off_i  = fo;
        force_full_i = ff;
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        check(pwm_gate_n_o == 1'b1, "R1 gate during reset", pwm_gate_n_o, 1);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_gate_n_o == 1'b1, "R1 gate after release", pwm_gate_n_o, 1);
        check({sat_full_o, sat_zero_o} == 2'b00, "R1 sat after release",
              {sat_full_o, sat_zero_o}, 0);
    endtask

    task automatic t_idle;
        window_check(0, 0, 0, "R1 R2 R8 idle no select");
        set_inputs(40, 1'b1, 1'b1, 1'b0, 1'b0);
        window_check(0, 0, 0, "R2 R8 both selected");
    endtask

    task automatic t_raise;
        set_inputs(5, 1'b1, 1'b0, 1'b0, 1'b0);
        window_check(0, 1, 0, "R8 overlap while raising");
        window_check(1, 0, 0, "R3 R5 first raise");
        window_check(2, 0, 0, "R3 second raise");
        window_check(3, 0, 0, "R3 third raise");
        set_inputs(40, 1'b0, 1'b0, 1'b0, 1'b0);
        window_check(3, 0, 0, "R2 hold at three");
    endtask

    task automatic t_force;
        set_inputs(40, 1'b0, 1'b0, 1'b0, 1'b1);
        window_check(P, 0, 0, "R7 force full");
        set_inputs(40, 1'b0, 1'b0, 1'b1, 1'b1);
        window_check(0, 0, 0, "R7 both forces off wins");
        set_inputs(40, 1'b0, 1'b0, 1'b1, 1'b0);
        window_check(0, 0, 0, "R7 force off");
    endtask

    task automatic t_lower;
        set_inputs(40, 1'b0, 1'b1, 1'b0, 1'b0);
        window_check(2, 0, 0, "R4 R7 lower after release");
        window_check(1, 0, 0, "R4 lower to one");
        window_check(0, 0, 1, "R6 R8 zero overlap holds off");
    endtask

    task automatic t_saturate;
        set_inputs(40, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int d = 1; d < P; d++) begin
            window_check(d, 0, 0, "R3 climb");
        end
        window_check(P, 1, 0, "R6 R8 full overlap holds on");
        window_check(1, 0, 0, "R9 wrap past full");
    endtask

    initial begin
        t_reset();
        t_idle();
        t_raise();
        t_force();
        t_lower();
        t_saturate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule